// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

A 32-pin general-purpose I/O bank with a small memory-mapped register file and per-pin interrupt detection. Software sets the output values and the drive direction of each pin. It reads back the pin levels after a two-flop synchroniser, and it sets up each pin to raise an interrupt on a low level, a high level, a falling edge or a rising edge. Per-pin enable and mask controls gate a raw status vector into a masked status vector. The OR of the masked status drives a single registered interrupt line.

All control registers are split into two halfword registers 4 bytes apart. The lower register holds pins 0..15 and the upper one holds pins 16..31. Every write to a split register carries a per-bit write enable in data bits 31:16. Because of this, one pin can be changed without a read-modify-write, and several pins can be set or cleared in one access. Edge events latch until software writes the pin's bit to the end-of-interrupt register. Level events track the pin and are never latched.

The bus is a single-cycle request interface with a byte address. A write takes effect at the clock edge where `req_i` and `we_i` are both high. Read data is registered and appears on `rdata_o` one cycle after the read request.

Top module: `gpio_irq_bank`

Word offsets (lower / upper half): output value 0x00/0x04, direction 0x08/0x0C, interrupt enable 0x10/0x14, mask 0x18/0x1C, trigger type 0x20/0x24, polarity 0x28/0x2C, end-of-interrupt 0x60/0x64. Full-width read-only words: masked status 0x50, raw status 0x58, external pin levels 0x70.

## Requirements
- R1: After reset, every output-value, direction, enable, mask, type and polarity bit is 0, all latched edge status is clear, and `irq_o` is 0.
- R2: A write to a split register at offset+0 (pins 0..15) or offset+4 (pins 16..31) changes stored bit i only where data bit 16+i is 1, and then loads data bit i.
- R3: A read of a split register returns its 16 stored bits in bits 15:0 and zero in bits 31:16. The end-of-interrupt words and unmapped offsets read zero. Writes to the status and pin-level words change no state.
- R4: The word at 0x70 returns all 32 pin levels after a two-stage synchroniser.
- R5: `pin_o` equals the stored output values and `pin_oe_o` equals the stored direction bits, where 1 means output.
- R6: A pin with type bit 0 (level) shows a raw status of 1 exactly while its synchronised level equals its polarity bit (0 = low, 1 = high). The bit is not latched.
- R7: A pin with type bit 1 (edge) latches raw status on a transition of its synchronised level toward its polarity bit (0 = falling, 1 = rising). The bit holds until an end-of-interrupt write has value 1 and enable 1 for that pin. Any other end-of-interrupt write leaves it set.
- R8: The masked status at 0x50 is raw AND enable AND NOT mask. `irq_o` is the registered OR of the masked status.
- R9: Writing 0xFFFF0000 to both enable halves clears every enable bit.
- R10: A pin whose direction bit is 1 never produces level status and never latches a new edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data; bits 31:16 are per-bit enables for split registers |
| rdata_o | output | 32 | Read data, valid one cycle after the read request |
| pin_i | input | 32 | Pin input levels, asynchronous |
| pin_o | output | 32 | Pin output values |
| pin_oe_o | output | 32 | Pin output enables (1 = drive) |
| irq_o | output | 1 | Bank interrupt line |

## Verification
The assertions assume that `pin_i` carries known values from reset onward, so the synchroniser check can compare the second stage with the pin value from two cycles earlier. They also assume that bus addresses are word-aligned whenever split registers are read. The stimulus drives every pin from time zero and changes pin levels only on the falling clock edge. It holds each level for at least five cycles before it samples status, so every pin event passes both synchroniser stages and the interrupt register before the bench looks at it. Bus requests are issued one at a time, with `req_i` dropped between accesses.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // word slot = byte address >> 3; bit 2 selects the upper half
  localparam int unsigned SLOT_DOUT = 0;
  localparam int unsigned SLOT_DIR  = 1;
  localparam int unsigned SLOT_EN   = 2;
  localparam int unsigned SLOT_MASK = 3;
  localparam int unsigned SLOT_TYPE = 4;
  localparam int unsigned SLOT_POL  = 5;
  localparam int unsigned NUM_CTRL  = 6;
  localparam int unsigned SLOT_STAT = 10;
  localparam int unsigned SLOT_RAW  = 11;
  localparam int unsigned SLOT_EOI  = 12;
  localparam int unsigned SLOT_EXT  = 14;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] in_en_i,
  input  logic [WIDTH-1:0] edge_sel_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] raw_o
);
  logic [WIDTH-1:0] prev_q, latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic hit, lvl_act;
    assign hit     = in_en_i[i] & edge_sel_i[i] &
                     (pol_i[i] ? (lvl_i[i] & ~prev_q[i]) : (~lvl_i[i] & prev_q[i]));
    assign lvl_act = in_en_i[i] & ~edge_sel_i[i] & (lvl_i[i] == pol_i[i]);

    // new event wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) latch_q[i] <= 1'b0;
      else         latch_q[i] <= hit | (latch_q[i] & ~clr_i[i]);
    end

    assign raw_o[i] = edge_sel_i[i] ? latch_q[i] : lvl_act;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*HALF_W-1:0] wdata_i,
  output logic [2*HALF_W-1:0] rdata_o,
  input  logic [2*HALF_W-1:0] pin_i,
  output logic [2*HALF_W-1:0] pin_o,
  output logic [2*HALF_W-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam int unsigned NUM_PINS = 2 * HALF_W;
  localparam int unsigned SLOT_W   = ADDR_W - 3;

  logic [SLOT_W-1:0] slot;
  logic              hi_sel, aligned, wr_en, rd_en;
  logic [HALF_W-1:0] wval, wmsk;

  assign slot    = addr_i[ADDR_W-1:3];
  assign hi_sel  = addr_i[2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr_en   = req_i & we_i & aligned;
  assign rd_en   = req_i & ~we_i;
  assign wval    = wdata_i[HALF_W-1:0];
  assign wmsk    = wdata_i[NUM_PINS-1:HALF_W];

  logic [NUM_CTRL-1:0][NUM_PINS-1:0] ctrl;

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
    logic [NUM_PINS-1:0] q;
    logic                hit;
    assign hit = wr_en && (slot == SLOT_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (hit) begin
        if (hi_sel) q[NUM_PINS-1:HALF_W] <= (q[NUM_PINS-1:HALF_W] & ~wmsk) | (wval & wmsk);
        else        q[HALF_W-1:0]        <= (q[HALF_W-1:0] & ~wmsk) | (wval & wmsk);
      end
    end
    assign ctrl[k] = q;
  end

  logic [NUM_PINS-1:0] dout, dir, en, msk, typ, pol;
  assign dout = ctrl[SLOT_DOUT];
  assign dir  = ctrl[SLOT_DIR];
  assign en   = ctrl[SLOT_EN];
  assign msk  = ctrl[SLOT_MASK];
  assign typ  = ctrl[SLOT_TYPE];
  assign pol  = ctrl[SLOT_POL];

  // end-of-interrupt pulse vector
  logic                eoi_hit;
  logic [NUM_PINS-1:0] eoi_clr;
  assign eoi_hit = wr_en && (slot == SLOT_W'(SLOT_EOI));
  assign eoi_clr = !eoi_hit ? '0 :
                   hi_sel   ? {wval & wmsk, {HALF_W{1'b0}}} :
                              {{HALF_W{1'b0}}, wval & wmsk};

  logic [NUM_PINS-1:0] lvl, raw, stat;

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  gpio_irq_detect #(.WIDTH(NUM_PINS)) u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .in_en_i   (~dir),
    .edge_sel_i(typ),
    .pol_i     (pol),
    .clr_i     (eoi_clr),
    .raw_o     (raw)
  );

  assign stat = raw & en & ~msk;

  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |stat;
  end

  // read path
  logic [NUM_PINS-1:0] rd_mux, rdata_q;
  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (slot < SLOT_W'(NUM_CTRL)) begin
        rd_mux[HALF_W-1:0] = hi_sel ? ctrl[slot[$clog2(NUM_CTRL)-1:0]][NUM_PINS-1:HALF_W]
                                    : ctrl[slot[$clog2(NUM_CTRL)-1:0]][HALF_W-1:0];
      end else if (!hi_sel) begin
        if (slot == SLOT_W'(SLOT_STAT))     rd_mux = stat;
        else if (slot == SLOT_W'(SLOT_RAW)) rd_mux = raw;
        else if (slot == SLOT_W'(SLOT_EXT)) rd_mux = lvl;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata_o  = rdata_q;
  assign pin_o    = dout;
  assign pin_oe_o = dir;
  assign irq_o    = irq_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] rdata_o,
  input logic [NUM_PINS-1:0] pin_i,
  input logic [NUM_PINS-1:0] lvl,
  input logic [NUM_PINS-1:0] raw,
  input logic [NUM_PINS-1:0] typ,
  input logic [NUM_PINS-1:0] dir,
  input logic [NUM_PINS-1:0] en,
  input logic [NUM_PINS-1:0] msk,
  input logic [NUM_PINS-1:0] eoi_clr,
  input logic                irq_o
);
  localparam int unsigned HALF_W = NUM_PINS / 2;

  logic [1:0] up_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          up_cnt <= '0;
    else if (up_cnt != 3) up_cnt <= up_cnt + 2'd1;
  end

  // R1
  always @(posedge clk_i) if (!rst_ni) reset_irq_low_chk: assert (irq_o == 1'b0);

  // R4
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt == 3) |-> (lvl == $past(pin_i, 2)));

  // R3
  split_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[1:0] == 2'b00 && addr_i[ADDR_W-1:3] < 6)
      |=> (rdata_o[NUM_PINS-1:HALF_W] == '0));

  // R7
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt != 0) |-> ((($past(raw & typ & ~eoi_clr)) & typ & ~raw) == '0));

  // R10
  output_no_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw & dir & ~typ) == '0));

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(raw & en & ~msk) != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(2*HALF_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .pin_i  (pin_i),
  .lvl    (lvl),
  .raw    (raw),
  .typ    (typ),
  .dir    (dir),
  .en     (en),
  .msk    (msk),
  .eoi_clr(eoi_clr),
  .irq_o  (irq_o)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
  localparam logic [7:0] A_DOUT = 8'h00, A_DIR = 8'h08, A_EN = 8'h10, A_MASK = 8'h18;
  localparam logic [7:0] A_TYPE = 8'h20, A_POL = 8'h28, A_STAT = 8'h50, A_RAW = 8'h58;
  localparam logic [7:0] A_EOI = 8'h60, A_EXT = 8'h70;

  logic        clk = 0, rst_ni = 0, req = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, pins = '0;
  logic [31:0] rdata, pin_o, pin_oe;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  gpio_irq_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic set_bit(input logic [7:0] base, input int p, input bit v);
    logic [7:0]  a;
    logic [31:0] d;
    a = base + ((p >= 16) ? 8'd4 : 8'd0);
    d = (32'h1 << (16 + p % 16)) | (v ? (32'h1 << (p % 16)) : 32'h0);
    wr(a, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    idle(2);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 pin_o", pin_o, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    for (int k = 0; k < 12; k++) begin
      rd(8'(k * 4), v);
      check("R1 ctrl", v, 32'h0);
    end
    rd(A_STAT, v); check("R1 stat", v, 32'h0);

    // R2 R5 write-enable halves
    wr(A_DOUT, 32'h0000FFFF); check("R2 no-enable", pin_o, 32'h0);
    wr(A_DOUT, 32'hFFFFA5A5); check("R5 pin_o lo", pin_o, 32'h0000A5A5);
    wr(A_DOUT, 32'h00FF0000); check("R2 partial", pin_o, 32'h0000A500);
    wr(A_DOUT + 8'd4, 32'hF0F01234); check("R2 upper", pin_o, 32'h1030A500);
    rd(A_DOUT + 8'd4, v); check("R3 upper read", v, 32'h00001030);
    rd(A_DOUT, v); check("R3 lower read", v, 32'h0000A500);
    wr(A_DIR + 8'd4, 32'hFFFF8001); check("R5 pin_oe", pin_oe, 32'h80010000);
    wr(A_DIR + 8'd4, 32'hFFFF0000); check("R5 pin_oe clr", pin_oe, 32'h0);
    wr(A_DOUT, 32'hFFFF0000); wr(A_DOUT + 8'd4, 32'hFFFF0000);

    // R9 enable clear
    wr(A_EN, 32'hFFFFFFFF); wr(A_EN + 8'd4, 32'hFFFFFFFF);
    rd(A_EN + 8'd4, v); check("R9 set", v, 32'h0000FFFF);
    wr(A_EN, 32'hFFFF0000); wr(A_EN + 8'd4, 32'hFFFF0000);
    rd(A_EN, v); check("R9 lo clr", v, 32'h0);
    rd(A_EN + 8'd4, v); check("R9 hi clr", v, 32'h0);

    // R3 read-only and zero words
    wr(A_RAW, 32'hFFFFFFFF); wr(A_STAT, 32'hFFFFFFFF); wr(A_EXT, 32'hFFFFFFFF);
    rd(A_EN, v); check("R3 ro no effect", v, 32'h0);
    rd(A_STAT, v); check("R3 stat ro", v, 32'h0);
    rd(A_EOI, v); check("R3 eoi zero", v, 32'h0);
    rd(8'h40, v); check("R3 unmapped", v, 32'h0);

    // R4 external pins
    pins = 32'hC3A5_5A3C; idle(3);
    rd(A_EXT, v); check("R4 ext", v, 32'hC3A5_5A3C);
    pins = 32'h0F0F_F0F0; idle(3);
    rd(A_EXT, v); check("R4 ext2", v, 32'h0F0F_F0F0);
    pins = 32'h0;

    // R10 output pin: level high configured, pin high, driven as output
    set_bit(A_DIR, 3, 1); set_bit(A_POL, 3, 1); pins[3] = 1; idle(5);
    rd(A_RAW, v); check("R10 no level", {31'b0, v[3]}, 32'h0);
    set_bit(A_TYPE, 3, 1); pins[3] = 0; idle(4); pins[3] = 1; idle(5);
    rd(A_RAW, v); check("R10 no edge", {31'b0, v[3]}, 32'h0);
    set_bit(A_DIR, 3, 0); set_bit(A_TYPE, 3, 0); set_bit(A_POL, 3, 0); pins[3] = 0;

    // R6 R7 R8 sweep: every pin, every trigger mode
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 4; m++) begin
        bit ty, po;
        ty = m[1]; po = m[0];
        pins[p] = ~po;
        set_bit(A_TYPE, p, ty); set_bit(A_POL, p, po); idle(4);
        set_bit(A_EOI, p, 1); set_bit(A_EN, p, 1); idle(3);
        rd(A_RAW, v); check(ty ? "R7 idle" : "R6 idle", {31'b0, v[p]}, 32'h0);
        check("R8 irq idle", {31'b0, irq}, 32'h0);

        pins[p] = po; idle(5);
        rd(A_RAW, v); check(ty ? "R7 set" : "R6 set", {31'b0, v[p]}, 32'h1);
        rd(A_STAT, v); check("R8 stat", v, 32'h1 << p);
        check("R8 irq on", {31'b0, irq}, 32'h1);

        set_bit(A_MASK, p, 1); idle(2);
        check("R8 masked irq", {31'b0, irq}, 32'h0);
        rd(A_STAT, v); check("R8 masked stat", v, 32'h0);
        set_bit(A_MASK, p, 0);

        pins[p] = ~po; idle(5);
        rd(A_RAW, v);
        if (ty) begin
          check("R7 held", {31'b0, v[p]}, 32'h1);
          wr(A_EOI + ((p >= 16) ? 8'd4 : 8'd0), 32'h1 << (p % 16)); idle(2);
          rd(A_RAW, v); check("R7 eoi no enable", {31'b0, v[p]}, 32'h1);
          set_bit(A_EOI, p, 0); idle(2);
          rd(A_RAW, v); check("R7 eoi zero", {31'b0, v[p]}, 32'h1);
          set_bit(A_EOI, p, 1); idle(2);
          rd(A_RAW, v); check("R7 cleared", {31'b0, v[p]}, 32'h0);
          check("R8 irq drop", {31'b0, irq}, 32'h0);
        end else begin
          check("R6 not latched", {31'b0, v[p]}, 32'h0);
          check("R8 irq drop", {31'b0, irq}, 32'h0);
        end

        set_bit(A_EN, p, 0); set_bit(A_TYPE, p, 0); set_bit(A_POL, p, 0);
        pins[p] = 0;
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule